// File: doc/BRIEF.md
# Load-Area Address Range Checker

This block validates the placement of an in-memory table of 16-byte register-load records before a guest entry uses it. It takes a 64-bit table base, a 32-bit record count, a physical-address width and a flag that restricts addresses to the low 4 GiB. From these it forms the address of the table's last byte with headroom beyond 64 bits. It then tests the base alignment and checks both the base and the last-byte address against the permitted address range.

A one-cycle start strobe samples the inputs. One clock later the block raises a one-cycle done pulse. At the same time it presents three violation flags and an overall pass verdict. All of these hold until the next start. An empty table, where the count is zero, is never checked and always passes.

Top module: `load_area_checker`

## Requirements
- R1: `doneOut` is high for exactly the one cycle after the clock edge that sampled `startIn` high.
- R2: A record count of zero yields all three violation flags low and `passOut` high, whatever the base, width or limit flag.
- R3: With a non-zero count, `misalignOut` is set exactly when base bits 3:0 are not all zero.
- R4: With a non-zero count, `baseRangeOut` is set when the base has any bit set at or above the effective width.
- R5: With a non-zero count, `endRangeOut` is set when base + 16*count - 1 has any bit set at or above the effective width.
- R6: The last-byte sum is formed at least 66 bits wide, so a carry past bit 63 is reported as an end violation and never wraps into range.
- R7: When `limit32In` is 1, the effective width is at most 32, so any set bit in 63:32 of the base or end address is a violation.
- R8: A `paWidthIn` value above 52 is treated as 52.
- R9: `passOut` is high exactly when all three violation flags are low.
- R10: Between start strobes the outputs hold their last result regardless of input changes.
- R11: After reset, `doneOut`, all violation flags and `passOut` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Sample inputs and evaluate |
| baseIn | input | 64 | Table base address |
| countIn | input | 32 | Number of 16-byte records |
| paWidthIn | input | 6 | Physical-address width in bits |
| limit32In | input | 1 | Restrict addresses to bits 31:0 |
| doneOut | output | 1 | Result valid pulse |
| misalignOut | output | 1 | Base not 16-byte aligned |
| baseRangeOut | output | 1 | Base exceeds the allowed width |
| endRangeOut | output | 1 | Last byte exceeds the allowed width |
| passOut | output | 1 | No violation found |

## Verification
Several vectors place the base and the table end just inside and just outside a 36-bit width. These separate base violations from end-only violations. A base near 2^64 with two records shows whether the end sum wraps, because only a wide sum flags the end. Further cases cover the 4 GiB limit, a width of 63, a width of zero and a maximal count with a zero count. They show that the limit narrows the width, that widths are clamped to 52, and that an empty table skips every check.

// File: rtl/lac_pkg.sv
package lac_pkg;
  typedef struct packed {
    logic capture;
    logic bypass;
  } lacStrobes_t;
endpackage

// File: rtl/lac_ctrl.sv
module lac_ctrl
  import lac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        countZero,
  output lacStrobes_t strobes,
  output logic        doneOut
);
  logic doneQ;

  always_comb begin
    strobes.capture = startIn;
    strobes.bypass  = startIn & countZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= startIn;
  end

  assign doneOut = doneQ;

  p_done_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> doneOut);
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> !doneOut);
endmodule

// File: rtl/lac_datapath.sv
module lac_datapath
  import lac_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int CNT_W     = 32,
  parameter int WID_W     = 6,
  parameter int MAX_PA    = 52,
  parameter int LIMIT_W   = 32,
  parameter int REC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  lacStrobes_t       strobes,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [WID_W-1:0]  paWidthIn,
  input  logic              limit32In,
  output logic              countZero,
  output logic              misalignOut,
  output logic              baseRangeOut,
  output logic              endRangeOut,
  output logic              passOut
);
  localparam int EXT_W = ADDR_W + REC_SHIFT;

  logic [WID_W-1:0] effWidth;
  logic [EXT_W-1:0] allowMask;
  logic [EXT_W-1:0] endAddr;
  logic [EXT_W-1:0] baseExt;
  logic             misalignC, baseBadC, endBadC;
  logic             misalignQ, baseBadQ, endBadQ, passQ;

  always_comb begin
    effWidth = paWidthIn;
    if (effWidth > WID_W'(MAX_PA))  effWidth = WID_W'(MAX_PA);
    if (limit32In && effWidth > WID_W'(LIMIT_W)) effWidth = WID_W'(LIMIT_W);
    allowMask = (EXT_W'(1) << effWidth) - EXT_W'(1);
    baseExt   = EXT_W'(baseIn);
    endAddr   = baseExt + (EXT_W'(countIn) << REC_SHIFT) - EXT_W'(1);
    countZero = (countIn == '0);
    misalignC = |baseIn[REC_SHIFT-1:0];
    baseBadC  = |(baseExt & ~allowMask);
    endBadC   = |(endAddr & ~allowMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      misalignQ <= 1'b0;
      baseBadQ  <= 1'b0;
      endBadQ   <= 1'b0;
      passQ     <= 1'b0;
    end else if (strobes.capture) begin
      if (strobes.bypass) begin
        misalignQ <= 1'b0;
        baseBadQ  <= 1'b0;
        endBadQ   <= 1'b0;
        passQ     <= 1'b1;
      end else begin
        misalignQ <= misalignC;
        baseBadQ  <= baseBadC;
        endBadQ   <= endBadC;
        passQ     <= ~(misalignC | baseBadC | endBadC);
      end
    end
  end

  assign misalignOut  = misalignQ;
  assign baseRangeOut = baseBadQ;
  assign endRangeOut  = endBadQ;
  assign passOut      = passQ;

  p_zero_count_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && countIn == '0) |=> (passOut && !misalignOut && !baseRangeOut && !endRangeOut));
  p_misalign_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && countIn != '0 && baseIn[REC_SHIFT-1:0] != '0) |=> misalignOut);
  p_pass_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    passOut |-> !(misalignOut || baseRangeOut || endRangeOut));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(passOut) && $stable(misalignOut) && $stable(baseRangeOut) && $stable(endRangeOut)));
endmodule

// File: rtl/load_area_checker.sv
module load_area_checker
  import lac_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int CNT_W   = 32,
  parameter int WID_W   = 6,
  parameter int MAX_PA  = 52,
  parameter int LIMIT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [WID_W-1:0]  paWidthIn,
  input  logic              limit32In,
  output logic              doneOut,
  output logic              misalignOut,
  output logic              baseRangeOut,
  output logic              endRangeOut,
  output logic              passOut
);
  lacStrobes_t strobes;
  logic        countZero;

  lac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .countZero(countZero),
    .strobes(strobes), .doneOut(doneOut)
  );

  lac_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WID_W(WID_W),
    .MAX_PA(MAX_PA), .LIMIT_W(LIMIT_W), .REC_SHIFT(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .baseIn(baseIn), .countIn(countIn), .paWidthIn(paWidthIn), .limit32In(limit32In),
    .countZero(countZero), .misalignOut(misalignOut), .baseRangeOut(baseRangeOut),
    .endRangeOut(endRangeOut), .passOut(passOut)
  );
endmodule

// File: tb/load_area_checker_bench.sv
module load_area_checker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [63:0] baseIn = '0;
  logic [31:0] countIn = '0;
  logic [5:0]  paWidthIn = '0;
  logic        limit32In = 1'b0;
  logic        doneOut, misalignOut, baseRangeOut, endRangeOut, passOut;
  int          runCount = 0;
  int          failCount = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  load_area_checker u_load_area_checker (
    .clk(clk), .rstN(rstN), .startIn(startIn), .baseIn(baseIn), .countIn(countIn),
    .paWidthIn(paWidthIn), .limit32In(limit32In), .doneOut(doneOut),
    .misalignOut(misalignOut), .baseRangeOut(baseRangeOut),
    .endRangeOut(endRangeOut), .passOut(passOut)
  );

  // {base, count, width, limit, expected {misalign, base, end}, requirement number}
  localparam int NV = 14;
  localparam logic [109:0] VECS [NV] = '{
    {64'h0000_0000_0000_1000, 32'd1,          6'd36, 1'b0, 3'b000, 4'd5},
    {64'h0000_0000_0000_1008, 32'd1,          6'd36, 1'b0, 3'b100, 4'd3},
    {64'h0000_0010_0000_0000, 32'd1,          6'd36, 1'b0, 3'b011, 4'd4},
    {64'h0000_000F_FFFF_FFF0, 32'd1,          6'd36, 1'b0, 3'b000, 4'd5},
    {64'h0000_000F_FFFF_FFF0, 32'd2,          6'd36, 1'b0, 3'b001, 4'd5},
    {64'h0000_0000_0000_0000, 32'hFFFF_FFFF,  6'd52, 1'b0, 3'b000, 4'd5},
    {64'h0000_0000_0000_1003, 32'd0,          6'd0,  1'b0, 3'b000, 4'd2},
    {64'h0000_0000_FFFF_FFF0, 32'd1,          6'd52, 1'b1, 3'b000, 4'd7},
    {64'h0000_0000_FFFF_FFF0, 32'd2,          6'd52, 1'b1, 3'b001, 4'd7},
    {64'h0000_0001_0000_0000, 32'd1,          6'd52, 1'b1, 3'b011, 4'd7},
    {64'h0010_0000_0000_0000, 32'd1,          6'd63, 1'b0, 3'b011, 4'd8},
    {64'hFFFF_FFFF_FFFF_FFF0, 32'd2,          6'd52, 1'b0, 3'b011, 4'd6},
    {64'h000F_FFFF_FFFF_FFF0, 32'd1,          6'd52, 1'b0, 3'b000, 4'd4},
    {64'h0000_0000_0000_0000, 32'd1,          6'd0,  1'b0, 3'b001, 4'd5}
  };

  function automatic string tagOf(input logic [3:0] n);
    case (n)
      4'd2: return "R2";  4'd3: return "R3";  4'd4: return "R4";
      4'd5: return "R5";  4'd6: return "R6";  4'd7: return "R7";
      4'd8: return "R8";  default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: {done,mis,base,end,pass} actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {doneOut, misalignOut, baseRangeOut, endRangeOut, passOut};
  endfunction

  task automatic runOne(input logic [63:0] b, input logic [31:0] c, input logic [5:0] w,
                        input logic l, input logic [2:0] flags, input string tag);
    @(negedge clk);
    baseIn = b; countIn = c; paWidthIn = w; limit32In = l; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(tag, outs(), {1'b1, flags, flags == 3'b000});
    check("R9", {4'b0, passOut}, {4'b0, ~|flags});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", outs(), 5'b00000);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++)
      runOne(VECS[i][109:46], VECS[i][45:14], VECS[i][13:8], VECS[i][7],
             VECS[i][6:4], tagOf(VECS[i][3:0]));
    // R1: done drops after one cycle
    @(negedge clk);
    check("R1", {doneOut, 4'b0}, 5'b0);
    // R10: a failing result holds while inputs change without start
    runOne(64'h0000_0000_0000_1008, 32'd1, 6'd36, 1'b0, 3'b100, "R3");
    @(negedge clk);
    baseIn = 64'h0; countIn = 32'd0; paWidthIn = 6'd52;
    repeat (3) @(negedge clk);
    check("R10", outs(), 5'b01000);
    // R2: zero count with every other input hostile
    runOne(64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 6'd0, 1'b1, 3'b000, "R2");
    // R11: reset clears a pass verdict
    rstN = 1'b0;
    @(negedge clk);
    check("R11", outs(), 5'b00000);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      runCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runCount, failCount);
      $finish;
    end
  end
endmodule